// File: doc/BRIEF.md
# Miss and Write Buffer Blocking Controller

This block sits between a cache's request side and its memory side. It holds two small allocation queues, one for outstanding misses and one for pending writes. Each accepted allocation is stamped with a sequence number drawn from one counter shared by both queues. The memory side later issues entries, and an issued entry leaves its queue. Misses are stored at block granularity. Writes and uncached reads keep their exact address and byte length.

Blocking toward the request side is a small mask of independent causes: the miss queue is full, the write buffer is full, or no free target slot is reported from outside. The request side is blocked while any cause is set. The block counts how many blocking episodes each cause started, and how many cycles each episode lasted. Allocations can also raise a memory-side bus request tagged with a cause. The earliest ready time among all pending entries is reported continuously.

Top module: `miss_wb_blocker`

## Requirements
- R1: `blockMask` bit 0 is the miss-queue-full cause, bit 1 is the write-buffer-full cause and bit 2 is the no-target cause. `blockOut` is high exactly while any mask bit is set. After reset the mask is zero.
- R2: An allocation that fills a queue (`allocKind` 0 or 2 for the miss queue, 1 for the write buffer) sets that queue's mask bit at the same clock edge.
- R3: Issuing an entry clears its queue's mask bit only when the queue was full before the issue and is no longer full after it. Other bits are untouched.
- R4: `noTgtSet` sets bit 2 and `noTgtClr` clears it. When both are high in the same cycle, neither has any effect.
- R5: A cause that is set while the mask is zero increments that cause's event counter in `blockEvtCnt` (field c at bits c*CNT_W). A cause that is set while the mask is already nonzero leaves the counters unchanged.
- R6: When the mask returns to zero, the lowest-numbered cause cleared in that cycle has its field in `blockCycCnt` increased by the number of cycles `blockOut` was high.
- R7: A cacheable miss (`allocKind`=0) stores its address with the low log2(BLK_BYTES) bits cleared, and a length of BLK_BYTES.
- R8: A write (`allocKind`=1, into the write buffer) and an uncached read (`allocKind`=2, into the miss queue) store their exact address and `allocSize`. `allocKind`=3 is rejected with `allocErr`.
- R9: Accepted allocations receive sequence numbers 0, 1, 2, … from one counter shared by both queues. Rejected ones consume no number.
- R10: One cycle after a command, `busReq` bit 0 is high for an accepted miss-queue allocation with `allocReqBus` set, bit 1 for the same into the write buffer, and bit 2 for `prefetchReq`.
- R11: `nextReady` is the minimum `allocReadyAt` over pending entries of both queues, and all ones when both queues are empty.
- R12: An allocation to a queue that is full before the edge is rejected with `allocErr`. It changes no entry, no sequence number, no mask bit and no bus request, even if an issue frees that queue in the same cycle.
- R13: An allocation takes the lowest free index of its queue. An issue of an index that is not pending is ignored (`issueAck` low). An accepted issue returns the entry's address, length and sequence number one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Allocation command valid |
| allocKind | input | 2 | 0 cacheable miss, 1 write, 2 uncached read, 3 invalid |
| allocAddr | input | ADDR_W | Request byte address |
| allocSize | input | LEN_W | Request byte length (write/uncached) |
| allocReadyAt | input | TIME_W | Cycle at which the entry becomes ready |
| allocReqBus | input | 1 | Raise a memory-side bus request on acceptance |
| issueValid | input | 1 | Mark an entry in service |
| issueQueue | input | 1 | 0 miss queue, 1 write buffer |
| issueIdx | input | IDX_W | Entry index to issue |
| noTgtSet | input | 1 | Raise the no-target cause |
| noTgtClr | input | 1 | Drop the no-target cause |
| prefetchReq | input | 1 | Prefetch bus request |
| allocAck | output | 1 | Allocation accepted (registered) |
| allocErr | output | 1 | Allocation rejected (registered) |
| allocQueue | output | 1 | Queue of accepted allocation |
| allocIdx | output | IDX_W | Entry index of accepted allocation |
| allocOrder | output | ORDER_W | Sequence number of accepted allocation |
| allocLineAddr | output | ADDR_W | Stored address |
| allocLen | output | LEN_W | Stored length |
| issueAck | output | 1 | Issue accepted (registered) |
| issueAddr | output | ADDR_W | Issued entry address |
| issueLen | output | LEN_W | Issued entry length |
| issueOrder | output | ORDER_W | Issued entry sequence number |
| blockOut | output | 1 | Request side blocked |
| blockMask | output | 3 | Per-cause blocked bits |
| busReq | output | 3 | Per-cause bus request pulses |
| nextReady | output | TIME_W | Earliest ready time of pending entries |
| blockEvtCnt | output | 3*CNT_W | Blocking episodes started per cause |
| blockCycCnt | output | 3*CNT_W | Blocked cycles charged per cause |

## Verification
A queue occupancy that has drifted away from its entries first shows up in `blockMask`. A mask bit that rises one allocation early or late, or a clear that comes on an issue from a queue that was not full, is visible at the edge where the command is taken. A wrong free-slot search shows on `allocIdx` in the next cycle. A stale pending bit shows as an accepted issue of an entry already taken, or as a `nextReady` value that does not fall back. A wrong start stamp or a charge to the wrong cause only appears when the mask returns to zero, so the scenarios deliberately close episodes through both queue causes and the external cause.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int NCAUSE    = 3;
  localparam int CAUSE_MISS = 0;
  localparam int CAUSE_WB   = 1;
  localparam int CAUSE_TGT  = 2;

  typedef enum logic [1:0] {
    KIND_MISS     = 2'd0,
    KIND_WRITE    = 2'd1,
    KIND_UNCACHED = 2'd2,
    KIND_BAD      = 2'd3
  } allocKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic doAlloc;
    logic allocQ;
    logic doIssue;
    logic issueQ;
    logic allocRej;
  } strobe_t;
endpackage

// File: rtl/bb_queue.sv
module bb_queue #(
  parameter int DEPTH   = 4,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 7,
  parameter int ORDER_W = 16,
  parameter int TIME_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [LEN_W-1:0]   wrLen,
  input  logic [ORDER_W-1:0] wrOrder,
  input  logic [TIME_W-1:0]  wrReady,
  input  logic               issueEn,
  input  logic [IDX_W-1:0]   issueIdx,
  output logic               full,
  output logic               almostFull,
  output logic [IDX_W-1:0]   freeIdx,
  output logic               idxPending,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [LEN_W-1:0]   rdLen,
  output logic [ORDER_W-1:0] rdOrder,
  output logic [TIME_W-1:0]  minReady
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]   pend;
  logic [ADDR_W-1:0]  eAddr  [DEPTH];
  logic [LEN_W-1:0]   eLen   [DEPTH];
  logic [ORDER_W-1:0] eOrder [DEPTH];
  logic [TIME_W-1:0]  eReady [DEPTH];
  logic [CNTW-1:0]    cnt;

  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!pend[i]) freeIdx = IDX_W'(i);
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CNTW'(pend[i]);
    idxPending = 1'b0;
    rdAddr = '0;
    rdLen = '0;
    rdOrder = '0;
    minReady = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (issueIdx == IDX_W'(i)) begin
        idxPending = pend[i];
        rdAddr = eAddr[i];
        rdLen = eLen[i];
        rdOrder = eOrder[i];
      end
      if (pend[i] && eReady[i] < minReady) minReady = eReady[i];
    end
  end

  assign full       = (cnt == CNTW'(DEPTH));
  assign almostFull = (cnt == CNTW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (allocEn && freeIdx == IDX_W'(i)) pend[i] <= 1'b1;
        if (issueEn && issueIdx == IDX_W'(i)) pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (allocEn && freeIdx == IDX_W'(i)) begin
        eAddr[i]  <= wrAddr;
        eLen[i]   <= wrLen;
        eOrder[i] <= wrOrder;
        eReady[i] <= wrReady;
      end
    end
  end
endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int MISS_DEPTH = 4,
  parameter int WB_DEPTH   = 8,
  parameter int ORDER_W    = 16,
  parameter int TIME_W     = 32,
  parameter int LEN_W      = 7,
  parameter int IDX_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [1:0]         allocKind,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [LEN_W-1:0]   allocSize,
  input  logic [TIME_W-1:0]  allocReadyAt,
  input  logic [IDX_W-1:0]   issueIdx,
  output logic [1:0]         qFull,
  output logic [1:0]         qAlmost,
  output logic [1:0]         qIdxPend,
  output logic               allocAck,
  output logic               allocErr,
  output logic               allocQueue,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [ORDER_W-1:0] allocOrder,
  output logic [ADDR_W-1:0]  allocLineAddr,
  output logic [LEN_W-1:0]   allocLen,
  output logic               issueAck,
  output logic [ADDR_W-1:0]  issueAddr,
  output logic [LEN_W-1:0]   issueLen,
  output logic [ORDER_W-1:0] issueOrder,
  output logic [TIME_W-1:0]  nextReady
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_BYTES - 1);

  logic [ORDER_W-1:0] orderCnt;
  logic [ADDR_W-1:0]  entAddr;
  logic [LEN_W-1:0]   entLen;
  logic [IDX_W-1:0]   freeIdx  [2];
  logic [ADDR_W-1:0]  rdAddr   [2];
  logic [LEN_W-1:0]   rdLen    [2];
  logic [ORDER_W-1:0] rdOrder  [2];
  logic [TIME_W-1:0]  minReady [2];

  always_comb begin
    if (allocKind == KIND_MISS) begin
      entAddr = allocAddr & ~BLK_MASK;
      entLen  = LEN_W'(BLK_BYTES);
    end else begin
      entAddr = allocAddr;
      entLen  = allocSize;
    end
  end

  for (genvar q = 0; q < 2; q++) begin : gQueue
    bb_queue #(
      .DEPTH  (q == 0 ? MISS_DEPTH : WB_DEPTH),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .ORDER_W(ORDER_W),
      .TIME_W (TIME_W)
    ) u_queue (
      .clk       (clk),
      .rstN      (rstN),
      .allocEn   (strb.doAlloc && (strb.allocQ == 1'(q))),
      .wrAddr    (entAddr),
      .wrLen     (entLen),
      .wrOrder   (orderCnt),
      .wrReady   (allocReadyAt),
      .issueEn   (strb.doIssue && (strb.issueQ == 1'(q))),
      .issueIdx  (issueIdx),
      .full      (qFull[q]),
      .almostFull(qAlmost[q]),
      .freeIdx   (freeIdx[q]),
      .idxPending(qIdxPend[q]),
      .rdAddr    (rdAddr[q]),
      .rdLen     (rdLen[q]),
      .rdOrder   (rdOrder[q]),
      .minReady  (minReady[q])
    );
  end

  assign nextReady = (minReady[0] < minReady[1]) ? minReady[0] : minReady[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      orderCnt      <= '0;
      allocAck      <= 1'b0;
      allocErr      <= 1'b0;
      allocQueue    <= 1'b0;
      allocIdx      <= '0;
      allocOrder    <= '0;
      allocLineAddr <= '0;
      allocLen      <= '0;
      issueAck      <= 1'b0;
      issueAddr     <= '0;
      issueLen      <= '0;
      issueOrder    <= '0;
    end else begin
      allocAck <= strb.doAlloc;
      allocErr <= strb.allocRej;
      issueAck <= strb.doIssue;
      if (strb.doAlloc) begin
        orderCnt      <= orderCnt + 1'b1;
        allocQueue    <= strb.allocQ;
        allocIdx      <= freeIdx[strb.allocQ];
        allocOrder    <= orderCnt;
        allocLineAddr <= entAddr;
        allocLen      <= entLen;
      end
      if (strb.doIssue) begin
        issueAddr  <= rdAddr[strb.issueQ];
        issueLen   <= rdLen[strb.issueQ];
        issueOrder <= rdOrder[strb.issueQ];
      end
    end
  end
endmodule

// File: rtl/bb_control.sv
module bb_control
  import bb_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    allocValid,
  input  logic [1:0]              allocKind,
  input  logic                    allocReqBus,
  input  logic                    issueValid,
  input  logic                    issueQueue,
  input  logic                    noTgtSet,
  input  logic                    noTgtClr,
  input  logic                    prefetchReq,
  input  logic [1:0]              qFull,
  input  logic [1:0]              qAlmost,
  input  logic [1:0]              qIdxPend,
  output strobe_t                 strb,
  output logic [NCAUSE-1:0]       blockMask,
  output logic                    blockOut,
  output logic [NCAUSE-1:0]       busReq,
  output logic [NCAUSE*CNT_W-1:0] evtFlat,
  output logic [NCAUSE*CNT_W-1:0] cycFlat
);
  logic [TIME_W-1:0] cycNow;
  logic [TIME_W-1:0] startCyc;
  logic [CNT_W-1:0]  evtCnt [NCAUSE];
  logic [CNT_W-1:0]  cycCnt [NCAUSE];
  logic [NCAUSE-1:0] setB;
  logic [NCAUSE-1:0] clrB;
  logic [NCAUSE-1:0] maskNext;
  logic              allocQ;
  logic              doAlloc;
  logic              doIssue;
  logic              goIdle;
  logic [1:0]        chargeIdx;

  assign allocQ  = (allocKind == KIND_WRITE);
  assign doAlloc = allocValid && (allocKind != KIND_BAD) && !qFull[allocQ];
  assign doIssue = issueValid && qIdxPend[issueQueue];

  always_comb begin
    strb.doAlloc  = doAlloc;
    strb.allocQ   = allocQ;
    strb.doIssue  = doIssue;
    strb.issueQ   = issueQueue;
    strb.allocRej = allocValid && !doAlloc;
    for (int q = 0; q < 2; q++) begin
      setB[q] = doAlloc && (allocQ == 1'(q)) && qAlmost[q] &&
                !(doIssue && issueQueue == 1'(q));
      clrB[q] = doIssue && (issueQueue == 1'(q)) && qFull[q];
    end
    setB[CAUSE_TGT] = noTgtSet && !noTgtClr;
    clrB[CAUSE_TGT] = noTgtClr && !noTgtSet && blockMask[CAUSE_TGT];
    maskNext = (blockMask & ~clrB) | setB;
    goIdle   = (blockMask != '0) && (maskNext == '0);
    chargeIdx = 2'd0;
    for (int c = NCAUSE - 1; c >= 0; c--)
      if (clrB[c]) chargeIdx = 2'(c);
  end

  assign blockOut = |blockMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycNow    <= '0;
      startCyc  <= '0;
      blockMask <= '0;
      busReq    <= '0;
      for (int c = 0; c < NCAUSE; c++) begin
        evtCnt[c] <= '0;
        cycCnt[c] <= '0;
      end
    end else begin
      cycNow    <= cycNow + 1'b1;
      blockMask <= maskNext;
      busReq    <= {prefetchReq,
                    doAlloc && allocQ && allocReqBus,
                    doAlloc && !allocQ && allocReqBus};
      if (blockMask == '0 && setB != '0) begin
        startCyc <= cycNow;
        for (int c = 0; c < NCAUSE; c++)
          if (setB[c]) evtCnt[c] <= evtCnt[c] + 1'b1;
      end
      if (goIdle)
        cycCnt[chargeIdx] <= cycCnt[chargeIdx] + CNT_W'(cycNow - startCyc);
    end
  end

  for (genvar c = 0; c < NCAUSE; c++) begin : gFlat
    assign evtFlat[c*CNT_W +: CNT_W] = evtCnt[c];
    assign cycFlat[c*CNT_W +: CNT_W] = cycCnt[c];
  end
endmodule

// File: rtl/miss_wb_blocker.sv
module miss_wb_blocker
  import bb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int MISS_DEPTH = 4,
  parameter int WB_DEPTH   = 8,
  parameter int ORDER_W    = 16,
  parameter int TIME_W     = 32,
  parameter int CNT_W      = 32,
  parameter int LEN_W      = $clog2(BLK_BYTES) + 1,
  parameter int IDX_W      = $clog2(MISS_DEPTH > WB_DEPTH ? MISS_DEPTH : WB_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic [1:0]           allocKind,
  input  logic [ADDR_W-1:0]    allocAddr,
  input  logic [LEN_W-1:0]     allocSize,
  input  logic [TIME_W-1:0]    allocReadyAt,
  input  logic                 allocReqBus,
  input  logic                 issueValid,
  input  logic                 issueQueue,
  input  logic [IDX_W-1:0]     issueIdx,
  input  logic                 noTgtSet,
  input  logic                 noTgtClr,
  input  logic                 prefetchReq,
  output logic                 allocAck,
  output logic                 allocErr,
  output logic                 allocQueue,
  output logic [IDX_W-1:0]     allocIdx,
  output logic [ORDER_W-1:0]   allocOrder,
  output logic [ADDR_W-1:0]    allocLineAddr,
  output logic [LEN_W-1:0]     allocLen,
  output logic                 issueAck,
  output logic [ADDR_W-1:0]    issueAddr,
  output logic [LEN_W-1:0]     issueLen,
  output logic [ORDER_W-1:0]   issueOrder,
  output logic                 blockOut,
  output logic [2:0]           blockMask,
  output logic [2:0]           busReq,
  output logic [TIME_W-1:0]    nextReady,
  output logic [3*CNT_W-1:0]   blockEvtCnt,
  output logic [3*CNT_W-1:0]   blockCycCnt
);
  strobe_t    strb;
  logic [1:0] qFull;
  logic [1:0] qAlmost;
  logic [1:0] qIdxPend;

  bb_control #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocKind(allocKind), .allocReqBus(allocReqBus),
    .issueValid(issueValid), .issueQueue(issueQueue),
    .noTgtSet(noTgtSet), .noTgtClr(noTgtClr), .prefetchReq(prefetchReq),
    .qFull(qFull), .qAlmost(qAlmost), .qIdxPend(qIdxPend),
    .strb(strb), .blockMask(blockMask), .blockOut(blockOut), .busReq(busReq),
    .evtFlat(blockEvtCnt), .cycFlat(blockCycCnt)
  );

  bb_datapath #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .MISS_DEPTH(MISS_DEPTH),
    .WB_DEPTH(WB_DEPTH), .ORDER_W(ORDER_W), .TIME_W(TIME_W),
    .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocKind(allocKind), .allocAddr(allocAddr), .allocSize(allocSize),
    .allocReadyAt(allocReadyAt), .issueIdx(issueIdx),
    .qFull(qFull), .qAlmost(qAlmost), .qIdxPend(qIdxPend),
    .allocAck(allocAck), .allocErr(allocErr), .allocQueue(allocQueue),
    .allocIdx(allocIdx), .allocOrder(allocOrder),
    .allocLineAddr(allocLineAddr), .allocLen(allocLen),
    .issueAck(issueAck), .issueAddr(issueAddr), .issueLen(issueLen),
    .issueOrder(issueOrder), .nextReady(nextReady)
  );
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
  parameter int ORDER_W = 16,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               allocValid,
  input logic [1:0]         allocKind,
  input logic               allocReqBus,
  input logic               prefetchReq,
  input logic               allocAck,
  input logic               allocErr,
  input logic [ORDER_W-1:0] allocOrder,
  input logic               blockOut,
  input logic [2:0]         blockMask,
  input logic [2:0]         busReq,
  input logic [1:0]         qFull,
  input logic [3*CNT_W-1:0] blockEvtCnt,
  input logic [3*CNT_W-1:0] blockCycCnt
);
  logic               seenAck;
  logic [ORDER_W-1:0] lastOrd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenAck <= 1'b0;
      lastOrd <= '0;
    end else if (allocAck) begin
      seenAck <= 1'b1;
      lastOrd <= allocOrder;
    end
  end

  // R2 / R3: queue bits track queue fullness
  assert_miss_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    blockMask[0] == qFull[0]);
  assert_wb_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    blockMask[1] == qFull[1]);

  // R12: allocation to a full queue is refused
  assert_full_reject_R12: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && qFull[allocKind == 2'd1]) |=> (allocErr && !allocAck));

  // R9: sequence numbers advance by one
  assert_order_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (allocAck && seenAck) |-> (allocOrder == lastOrd + 1'b1));

  // R10: bus requests have a cause one cycle earlier
  assert_miss_busreq_R10: assert property (@(posedge clk) disable iff (!rstN)
    busReq[0] |-> $past(allocValid && allocReqBus && (allocKind == 2'd0 || allocKind == 2'd2)));
  assert_pf_busreq_R10: assert property (@(posedge clk) disable iff (!rstN)
    busReq[2] |-> $past(prefetchReq));

  // R5: each episode start counts an event
  assert_event_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockOut) |-> (blockEvtCnt != $past(blockEvtCnt)));

  // R6: each episode end charges cycles
  assert_cycle_charge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(blockOut) |-> (blockCycCnt != $past(blockCycCnt)));
endmodule

bind miss_wb_blocker bb_checker #(.ORDER_W(ORDER_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocKind(allocKind),
  .allocReqBus(allocReqBus), .prefetchReq(prefetchReq), .allocAck(allocAck),
  .allocErr(allocErr), .allocOrder(allocOrder), .blockOut(blockOut),
  .blockMask(blockMask), .busReq(busReq), .qFull(qFull),
  .blockEvtCnt(blockEvtCnt), .blockCycCnt(blockCycCnt)
);

// File: tb/miss_wb_blocker_bench.sv
module miss_wb_blocker_bench;
  localparam int AW = 32, LW = 7, IW = 3, OW = 16, TW = 32, CW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 0, allocReqBus = 0, issueValid = 0, issueQueue = 0;
  logic noTgtSet = 0, noTgtClr = 0, prefetchReq = 0;
  logic [1:0] allocKind = 0;
  logic [AW-1:0] allocAddr = 0;
  logic [LW-1:0] allocSize = 0;
  logic [TW-1:0] allocReadyAt = 0;
  logic [IW-1:0] issueIdx = 0;
  logic allocAck, allocErr, allocQueue, issueAck, blockOut;
  logic [IW-1:0] allocIdx;
  logic [OW-1:0] allocOrder, issueOrder;
  logic [AW-1:0] allocLineAddr, issueAddr;
  logic [LW-1:0] allocLen, issueLen;
  logic [2:0] blockMask, busReq;
  logic [TW-1:0] nextReady;
  logic [3*CW-1:0] blockEvtCnt, blockCycCnt;

  int checks = 0, fails = 0, cyc = 0, tStart = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  miss_wb_blocker u_miss_wb_blocker (.*);

  function automatic longint evt(int c); return longint'(blockEvtCnt[c*CW +: CW]); endfunction
  function automatic longint bcyc(int c); return longint'(blockCycCnt[c*CW +: CW]); endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    allocValid = 0; allocReqBus = 0; issueValid = 0;
    noTgtSet = 0; noTgtClr = 0; prefetchReq = 0;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [LW-1:0] s, input logic [TW-1:0] r, input logic rb);
    @(negedge clk);
    allocValid = 1; allocKind = k; allocAddr = a; allocSize = s;
    allocReadyAt = r; allocReqBus = rb;
    tick();
  endtask

  task automatic issue(input logic q, input logic [IW-1:0] i);
    @(negedge clk);
    issueValid = 1; issueQueue = q; issueIdx = i;
    tick();
  endtask

  task automatic tgt(input logic s, input logic c);
    @(negedge clk);
    noTgtSet = s; noTgtClr = c;
    tick();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    eq("R1 reset mask", blockMask, 0);
    eq("R1 reset blockOut", blockOut, 0);
    eq("R10 reset busReq", busReq, 0);
    eq("R11 empty nextReady", nextReady, 32'hFFFF_FFFF);
    eq("R5 reset events", blockEvtCnt == '0, 1);
  endtask

  task automatic t_alloc_kinds();
    alloc(2'd0, 32'h1234_5678, 7'd3, 32'd100, 1);
    eq("R7 miss ack", allocAck, 1);
    eq("R7 aligned addr", allocLineAddr, 32'h1234_5640);
    eq("R7 block len", allocLen, 64);
    eq("R13 first idx", allocIdx, 0);
    eq("R9 first order", allocOrder, 0);
    eq("R10 miss busReq", busReq, 3'b001);
    eq("R11 nextReady one", nextReady, 100);
    alloc(2'd2, 32'h0000_1003, 7'd4, 32'd50, 0);
    eq("R8 uncached addr", allocLineAddr, 32'h1003);
    eq("R8 uncached len", allocLen, 4);
    eq("R8 uncached queue", allocQueue, 0);
    eq("R13 second idx", allocIdx, 1);
    eq("R9 second order", allocOrder, 1);
    eq("R10 no busReq", busReq, 0);
    eq("R11 nextReady min", nextReady, 50);
    alloc(2'd1, 32'h0000_2002, 7'd2, 32'd70, 1);
    eq("R8 write queue", allocQueue, 1);
    eq("R8 write addr", allocLineAddr, 32'h2002);
    eq("R8 write len", allocLen, 2);
    eq("R9 shared order", allocOrder, 2);
    eq("R10 wb busReq", busReq, 3'b010);
    alloc(2'd3, 32'h0000_4000, 7'd1, 32'd10, 1);
    eq("R8 bad kind err", allocErr, 1);
    eq("R8 bad kind ack", allocAck, 0);
    eq("R12 bad kind no busReq", busReq, 0);
    eq("R11 bad kind no entry", nextReady, 50);
  endtask

  task automatic t_fill_miss();
    alloc(2'd0, 32'h0000_00C5, 7'd1, 32'd200, 0);
    eq("R9 order after reject", allocOrder, 3);
    eq("R2 not full yet", blockMask, 0);
    alloc(2'd0, 32'h0000_007F, 7'd1, 32'd300, 0);
    tStart = cyc;
    eq("R7 aligned 7F", allocLineAddr, 32'h40);
    eq("R2 miss full bit", blockMask, 3'b001);
    eq("R1 blockOut high", blockOut, 1);
    eq("R5 miss event", evt(0), 1);
    alloc(2'd0, 32'h0000_9000, 7'd1, 32'd5, 1);
    eq("R12 full err", allocErr, 1);
    eq("R12 full no busReq", busReq, 0);
    eq("R12 full no entry", nextReady, 50);
  endtask

  task automatic t_target_cause();
    tgt(1, 0);
    eq("R4 target bit", blockMask, 3'b101);
    eq("R5 no event when blocked", evt(2), 0);
    issue(0, 3'd1);
    eq("R13 issue ack", issueAck, 1);
    eq("R13 issue addr", issueAddr, 32'h1003);
    eq("R13 issue len", issueLen, 4);
    eq("R13 issue order", issueOrder, 1);
    eq("R3 miss bit cleared", blockMask, 3'b100);
    eq("R6 nothing charged", blockCycCnt == '0, 1);
    eq("R11 after issue", nextReady, 70);
    issue(0, 3'd1);
    eq("R13 stale issue ignored", issueAck, 0);
    tgt(1, 1);
    eq("R4 both ignored", blockMask, 3'b100);
    tgt(0, 1);
    eq("R4 target cleared", blockMask, 0);
    eq("R1 blockOut low", blockOut, 0);
    eq("R6 target cycles", bcyc(2), cyc - tStart);
    eq("R6 miss cycles zero", bcyc(0), 0);
  endtask

  task automatic t_refill_and_release();
    alloc(2'd0, 32'h0000_1000, 7'd1, 32'd40, 0);
    tStart = cyc;
    eq("R13 lowest free idx", allocIdx, 1);
    eq("R9 order five", allocOrder, 5);
    eq("R2 refull", blockMask, 3'b001);
    eq("R5 second miss event", evt(0), 2);
    eq("R11 new min", nextReady, 40);
    repeat (3) @(posedge clk);
    #1;
    issue(0, 3'd0);
    eq("R3 release", blockMask, 0);
    eq("R6 miss cycles", bcyc(0), cyc - tStart);
  endtask

  task automatic t_fill_wb();
    for (int i = 1; i <= 7; i++) begin
      alloc(2'd1, 32'h3000 + i, 7'd1, 32'd1000, 0);
      if (i == 6) eq("R2 wb not full", blockMask, 0);
    end
    tStart = cyc;
    eq("R13 wb last idx", allocIdx, 7);
    eq("R9 wb last order", allocOrder, 12);
    eq("R2 wb full bit", blockMask, 3'b010);
    eq("R5 wb event", evt(1), 1);
    @(negedge clk);
    allocValid = 1; allocKind = 2'd1; allocAddr = 32'h5555; allocSize = 7'd1;
    allocReadyAt = 32'd1; allocReqBus = 1;
    issueValid = 1; issueQueue = 1; issueIdx = 3'd0;
    tick();
    eq("R12 full pre-state err", allocErr, 1);
    eq("R12 no wb busReq", busReq, 0);
    eq("R13 wb issue addr", issueAddr, 32'h2002);
    eq("R13 wb issue order", issueOrder, 2);
    eq("R3 wb bit cleared", blockMask, 0);
    eq("R6 wb cycles", bcyc(1), cyc - tStart);
    eq("R11 no entry from reject", nextReady, 40);
    alloc(2'd1, 32'h6000, 7'd1, 32'd2000, 0);
    eq("R9 order after reject wb", allocOrder, 13);
  endtask

  task automatic t_prefetch();
    @(negedge clk);
    prefetchReq = 1;
    tick();
    eq("R10 prefetch busReq", busReq, 3'b100);
    @(posedge clk); #1;
    eq("R10 pulse ends", busReq, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_alloc_kinds();
    t_fill_miss();
    t_target_cause();
    t_refill_and_release();
    t_fill_wb();
    t_prefetch();
    report();
  end
endmodule